// File: doc/BRIEF.md
# Speculative Switch Allocator with Pessimistic Masking

This block builds the crossbar schedule of a virtual-channel router once per cycle. Each input VC may raise one of two kinds of request, each naming an output port. A non-speculative request comes from a VC that already owns a downstream VC. A speculative request comes from a head flit whose VC allocation is still in flight. Two input-first separable allocators, one per request kind, run side by side. Each allocator has a round-robin VC arbiter per input port and a round-robin input arbiter per output port.

A speculative grant is kept only when no non-speculative request exists at its input port and none targets its output port. The conflict test looks only at the requests, so it runs while both allocators settle and never waits for their grants. It is pessimistic: a non-speculative request that loses its own arbitration still cancels the speculative grant it conflicts with. The surviving grants are registered. Each input port gets the index of its granted VC and a flag saying whether the grant is speculative. Each output port gets a crossbar select naming the input port it connects to.

Top module: `spec_switch_alloc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `gnt_valid`, `gnt_vc`, `gnt_spec`, `xbar_valid` and `xbar_src` are all zero.
- R2: The grant outputs are registered. They reflect the requests sampled at the previous rising clock edge and do not change between edges.
- R3: Each input port gets at most one grant per cycle. Request k = i*V+v is VC v of input port i. The granted VC index is `gnt_vc[i*VW +: VW]`, and that VC raised a request in the sampled cycle.
- R4: Each output port is connected to at most one input per cycle. `xbar_valid[o]` with `xbar_src[o*PW +: PW]` = i means that input i holds a grant whose request named port o. The number of set `xbar_valid` bits equals the number of set `gnt_valid` bits.
- R5: A non-speculative request with no competitor is granted with `gnt_spec` = 0. The output port of request k is `ns_dest[k*PW +: PW]` for non-speculative requests and `sp_dest[k*PW +: PW]` for speculative ones.
- R6: A speculative grant is dropped when any non-speculative request is present at the same input port, even if that request loses its own arbitration.
- R7: A speculative grant is dropped when any non-speculative request names the same output port, even if that request is not granted.
- R8: When no non-speculative request is present, a speculative request with no competitor is granted in the next cycle with `gnt_spec[i]` = 1.
- R9: VCs of one input port that keep requesting are served in round-robin order, starting from VC 0 after reset.
- R10: Input ports that compete for one output are served in round-robin order, starting from input 0 after reset.
- R11: An arbiter pointer moves only when its grant survives to the outputs. A masked speculative grant leaves the speculative arbiters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ns_req | input | P*V | Non-speculative request per input VC |
| ns_dest | input | P*V*PW | Output port named by each non-speculative request |
| sp_req | input | P*V | Speculative request per input VC |
| sp_dest | input | P*V*PW | Output port named by each speculative request |
| gnt_valid | output | P | Input port holds a grant this cycle |
| gnt_vc | output | P*VW | Granted VC index per input port |
| gnt_spec | output | P | Grant of the input port is speculative |
| xbar_valid | output | P | Output port is connected this cycle |
| xbar_src | output | P*PW | Input port driving each output port |

## Verification
The bench targets the pessimistic cases. In one, a non-speculative request loses at its output yet still cancels a speculative grant at the same input or at the same output. A design that masked with the non-speculative grants would let that speculative flit through. Another case lets a speculative grant be masked and then repeats the request. A design that moved its pointer on the masked grant would serve the wrong VC next. Round-robin sequences at an input and at an output show whether the pointers start at zero and rotate, and a full four-way permutation checks the crossbar select encoding.

// File: rtl/swa_pkg.sv
package swa_pkg;

    // index width for n items, never narrower than one bit
    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // source of the final grant at one input port
    typedef enum logic [1:0] {
        GK_NONE    = 2'd0,
        GK_NONSPEC = 2'd1,
        GK_SPEC    = 2'd2
    } grant_kind_e;

endpackage

// File: rtl/swa_rr_arb.sv
module swa_rr_arb #(
    parameter  int N = 4,
    localparam int W = swa_pkg::idx_w(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);

    logic [W-1:0] ptr_q;
    logic [W-1:0] win_idx;
    logic         win_any;

    // first requester at or after the pointer, wrapping
    always_comb begin
        gnt     = '0;
        win_idx = '0;
        win_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (!win_any && req[j]) begin
                win_any = 1'b1;
                gnt[j]  = 1'b1;
                win_idx = W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv && win_any) begin
            ptr_q <= (win_idx == W'(N - 1)) ? '0 : win_idx + W'(1);
        end
    end

endmodule

// File: rtl/swa_sep_alloc.sv
module swa_sep_alloc #(
    parameter  int P  = 4,
    parameter  int V  = 2,
    localparam int PW = swa_pkg::idx_w(P),
    localparam int VW = swa_pkg::idx_w(V)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [P*V-1:0]  req,
    input  logic [P*V*PW-1:0] dest,
    input  logic [P-1:0]    adv_in,
    input  logic [P-1:0]    adv_out,
    output logic [P-1:0]    in_gnt,
    output logic [P*VW-1:0] in_vc,
    output logic [P*PW-1:0] in_dest
);

    logic [V-1:0]  s1_gnt  [P];
    logic [VW-1:0] s1_vc   [P];
    logic [PW-1:0] s1_dest [P];
    logic [P-1:0]  out_req [P];
    logic [P-1:0]  out_gnt [P];

    // stage 1: one VC per input port
    for (genvar i = 0; i < P; i++) begin : g_in_arb
        swa_rr_arb #(.N(V)) u_vc_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[i*V +: V]),
            .adv   (adv_in[i]),
            .gnt   (s1_gnt[i])
        );
    end

    always_comb begin
        for (int i = 0; i < P; i++) begin
            s1_vc[i]   = '0;
            s1_dest[i] = '0;
            for (int v = 0; v < V; v++) begin
                if (s1_gnt[i][v]) begin
                    s1_vc[i]   = VW'(v);
                    s1_dest[i] = dest[(i*V + v)*PW +: PW];
                end
            end
        end
    end

    // stage 2: one input port per output
    always_comb begin
        for (int o = 0; o < P; o++) begin
            for (int i = 0; i < P; i++) begin
                out_req[o][i] = (|s1_gnt[i]) && (s1_dest[i] == PW'(o));
            end
        end
    end

    for (genvar o = 0; o < P; o++) begin : g_out_arb
        swa_rr_arb #(.N(P)) u_port_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (out_req[o]),
            .adv   (adv_out[o]),
            .gnt   (out_gnt[o])
        );
    end

    always_comb begin
        for (int i = 0; i < P; i++) begin
            in_gnt[i] = 1'b0;
            for (int o = 0; o < P; o++) begin
                in_gnt[i] = in_gnt[i] | out_gnt[o][i];
            end
            in_vc[i*VW +: VW]   = s1_vc[i];
            in_dest[i*PW +: PW] = s1_dest[i];
        end
    end

endmodule

// File: rtl/spec_switch_alloc.sv
module spec_switch_alloc #(
    parameter  int P  = 4,
    parameter  int V  = 2,
    localparam int PW = swa_pkg::idx_w(P),
    localparam int VW = swa_pkg::idx_w(V)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P*V-1:0]    ns_req,
    input  logic [P*V*PW-1:0] ns_dest,
    input  logic [P*V-1:0]    sp_req,
    input  logic [P*V*PW-1:0] sp_dest,
    output logic [P-1:0]      gnt_valid,
    output logic [P*VW-1:0]   gnt_vc,
    output logic [P-1:0]      gnt_spec,
    output logic [P-1:0]      xbar_valid,
    output logic [P*PW-1:0]   xbar_src
);

    import swa_pkg::*;

    logic [P-1:0]    ns_gnt,  sp_gnt;
    logic [P*VW-1:0] ns_vc,   sp_vc;
    logic [P*PW-1:0] ns_d,    sp_d;
    logic [P-1:0]    ns_adv_out, sp_adv_out;
    logic [P-1:0]    ns_in_busy, ns_out_busy, sp_keep;
    grant_kind_e     kind [P];

    logic [P-1:0]    valid_d, spec_d, xv_d;
    logic [P*VW-1:0] vc_d;
    logic [P*PW-1:0] dest_d, xs_d;

    swa_sep_alloc #(.P(P), .V(V)) u_ns_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ns_req),
        .dest    (ns_dest),
        .adv_in  (ns_gnt),
        .adv_out (ns_adv_out),
        .in_gnt  (ns_gnt),
        .in_vc   (ns_vc),
        .in_dest (ns_d)
    );

    swa_sep_alloc #(.P(P), .V(V)) u_sp_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (sp_req),
        .dest    (sp_dest),
        .adv_in  (sp_keep),
        .adv_out (sp_adv_out),
        .in_gnt  (sp_gnt),
        .in_vc   (sp_vc),
        .in_dest (sp_d)
    );

    // conflict detection from requests only, parallel to both allocators
    always_comb begin
        ns_out_busy = '0;
        for (int i = 0; i < P; i++) begin
            ns_in_busy[i] = |ns_req[i*V +: V];
        end
        for (int k = 0; k < P*V; k++) begin
            for (int o = 0; o < P; o++) begin
                if (ns_req[k] && ns_dest[k*PW +: PW] == PW'(o)) ns_out_busy[o] = 1'b1;
            end
        end
    end

    // pessimistic mask on speculative grants
    always_comb begin
        for (int i = 0; i < P; i++) begin
            sp_keep[i] = sp_gnt[i] && !ns_in_busy[i] && !ns_out_busy[sp_d[i*PW +: PW]];
        end
    end

    // pointer advance at outputs on surviving grants only
    always_comb begin
        ns_adv_out = '0;
        sp_adv_out = '0;
        for (int i = 0; i < P; i++) begin
            for (int o = 0; o < P; o++) begin
                if (ns_gnt[i]  && ns_d[i*PW +: PW] == PW'(o)) ns_adv_out[o] = 1'b1;
                if (sp_keep[i] && sp_d[i*PW +: PW] == PW'(o)) sp_adv_out[o] = 1'b1;
            end
        end
    end

    // merge into the final schedule
    always_comb begin
        for (int i = 0; i < P; i++) begin
            if (ns_gnt[i])       kind[i] = GK_NONSPEC;
            else if (sp_keep[i]) kind[i] = GK_SPEC;
            else                 kind[i] = GK_NONE;
        end
    end

    always_comb begin
        for (int i = 0; i < P; i++) begin
            unique case (kind[i])
                GK_NONSPEC: begin
                    valid_d[i]          = 1'b1;
                    spec_d[i]           = 1'b0;
                    vc_d[i*VW +: VW]    = ns_vc[i*VW +: VW];
                    dest_d[i*PW +: PW]  = ns_d[i*PW +: PW];
                end
                GK_SPEC: begin
                    valid_d[i]          = 1'b1;
                    spec_d[i]           = 1'b1;
                    vc_d[i*VW +: VW]    = sp_vc[i*VW +: VW];
                    dest_d[i*PW +: PW]  = sp_d[i*PW +: PW];
                end
                default: begin
                    valid_d[i]          = 1'b0;
                    spec_d[i]           = 1'b0;
                    vc_d[i*VW +: VW]    = '0;
                    dest_d[i*PW +: PW]  = '0;
                end
            endcase
        end
    end

    always_comb begin
        xv_d = '0;
        xs_d = '0;
        for (int o = 0; o < P; o++) begin
            for (int i = 0; i < P; i++) begin
                if (valid_d[i] && dest_d[i*PW +: PW] == PW'(o)) begin
                    xv_d[o]          = 1'b1;
                    xs_d[o*PW +: PW] = PW'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid  <= '0;
            gnt_vc     <= '0;
            gnt_spec   <= '0;
            xbar_valid <= '0;
            xbar_src   <= '0;
        end else begin
            gnt_valid  <= valid_d;
            gnt_vc     <= vc_d;
            gnt_spec   <= spec_d;
            xbar_valid <= xv_d;
            xbar_src   <= xs_d;
        end
    end

endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
    parameter  int P  = 4,
    parameter  int V  = 2,
    localparam int PW = swa_pkg::idx_w(P),
    localparam int VW = swa_pkg::idx_w(V)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [P*V-1:0]    ns_req,
    input logic [P*V*PW-1:0] ns_dest,
    input logic [P*V-1:0]    sp_req,
    input logic [P-1:0]      gnt_valid,
    input logic [P*VW-1:0]   gnt_vc,
    input logic [P-1:0]      gnt_spec,
    input logic [P-1:0]      xbar_valid,
    input logic [P*PW-1:0]   xbar_src
);

    logic [P*V-1:0]    prev_ns, prev_sp;
    logic [P*V*PW-1:0] prev_nsd;
    logic [P-1:0]      prev_in_busy, prev_out_busy, vc_ok, spec_at_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ns  <= '0;
            prev_sp  <= '0;
            prev_nsd <= '0;
        end else begin
            prev_ns  <= ns_req;
            prev_sp  <= sp_req;
            prev_nsd <= ns_dest;
        end
    end

    always_comb begin
        prev_out_busy = '0;
        for (int i = 0; i < P; i++) begin
            prev_in_busy[i] = |prev_ns[i*V +: V];
            vc_ok[i] = 1'b0;
            for (int v = 0; v < V; v++) begin
                if (gnt_vc[i*VW +: VW] == VW'(v)) vc_ok[i] = prev_ns[i*V + v] | prev_sp[i*V + v];
            end
        end
        for (int k = 0; k < P*V; k++) begin
            for (int o = 0; o < P; o++) begin
                if (prev_ns[k] && prev_nsd[k*PW +: PW] == PW'(o)) prev_out_busy[o] = 1'b1;
            end
        end
        for (int o = 0; o < P; o++) begin
            spec_at_out[o] = xbar_valid[o] && gnt_spec[xbar_src[o*PW +: PW]];
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (gnt_valid == '0 && xbar_valid == '0));

    assert_count_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_valid) == $countones(xbar_valid));

    assert_lone_nonspec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_sp == '0 && $countones(prev_ns) == 1) |-> ($countones(gnt_valid) == 1 && gnt_spec == '0));

    assert_lone_spec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ns == '0 && $countones(prev_sp) == 1) |-> ($countones(gnt_spec) == 1));

    for (genvar i = 0; i < P; i++) begin : g_in_chk
        assert_vc_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[i] |-> vc_ok[i]);
        assert_spec_input_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_spec[i] |-> !prev_in_busy[i]);
        assert_spec_flag_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_spec[i] |-> gnt_valid[i]);
    end

    for (genvar o = 0; o < P; o++) begin : g_out_chk
        assert_xbar_src_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
            xbar_valid[o] |-> gnt_valid[xbar_src[o*PW +: PW]]);
        assert_spec_output_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            spec_at_out[o] |-> !prev_out_busy[o]);
    end

endmodule

bind spec_switch_alloc swa_checker #(.P(P), .V(V)) u_swa_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ns_req     (ns_req),
    .ns_dest    (ns_dest),
    .sp_req     (sp_req),
    .gnt_valid  (gnt_valid),
    .gnt_vc     (gnt_vc),
    .gnt_spec   (gnt_spec),
    .xbar_valid (xbar_valid),
    .xbar_src   (xbar_src)
);

// File: tb/tb_spec_switch_alloc.sv
module tb_spec_switch_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ns_req = '0;
    logic [15:0] ns_dest = '0;
    logic [7:0]  sp_req = '0;
    logic [15:0] sp_dest = '0;
    logic [3:0]  gnt_valid, gnt_vc, gnt_spec, xbar_valid;
    logic [7:0]  xbar_src;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    spec_switch_alloc #(.P(4), .V(2)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ns_req     (ns_req),
        .ns_dest    (ns_dest),
        .sp_req     (sp_req),
        .sp_dest    (sp_dest),
        .gnt_valid  (gnt_valid),
        .gnt_vc     (gnt_vc),
        .gnt_spec   (gnt_spec),
        .xbar_valid (xbar_valid),
        .xbar_src   (xbar_src)
    );

    typedef struct packed {
        logic [7:0]  nsr;
        logic [15:0] nsd;
        logic [7:0]  spr;
        logic [15:0] spd;
        logic [3:0]  ev;
        logic [3:0]  evc;
        logic [3:0]  esp;
        logic [3:0]  exv;
        logic [7:0]  exs;
    } vec_t;

    // each vector is applied from a fresh reset
    localparam vec_t VECS [9] = '{
        '{8'h00, 16'h0000, 8'h00, 16'h0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'h00}, // idle R2
        '{8'h08, 16'h0080, 8'h00, 16'h0000, 4'b0010, 4'b0010, 4'b0000, 4'b0100, 8'h10}, // lone nonspec R5
        '{8'h00, 16'h0000, 8'h10, 16'h0300, 4'b0100, 4'b0000, 4'b0100, 4'b1000, 8'h80}, // lone spec R8
        '{8'h01, 16'h0001, 8'h02, 16'h0008, 4'b0001, 4'b0000, 4'b0000, 4'b0010, 8'h00}, // same input R6
        '{8'h05, 16'h0022, 8'h40, 16'h2000, 4'b0001, 4'b0000, 4'b0000, 4'b0100, 8'h00}, // losing ns at output R7
        '{8'h11, 16'h0101, 8'h60, 16'h0C00, 4'b1001, 4'b0000, 4'b1000, 4'b0011, 8'h03}, // losing ns at input R6
        '{8'hAA, 16'h048C, 8'h00, 16'h0000, 4'b1111, 4'b1111, 4'b0000, 4'b1111, 8'h1B}, // permutation R4
        '{8'h00, 16'h0000, 8'h24, 16'h0000, 4'b0010, 4'b0000, 4'b0010, 4'b0001, 8'h01}, // spec contention R10
        '{8'h0C, 16'h0030, 8'h00, 16'h0000, 4'b0010, 4'b0000, 4'b0000, 4'b1000, 8'h40}  // two VCs one port R3
    };

    task automatic check(input string tag, input logic [3:0] ev, input logic [3:0] evc,
                         input logic [3:0] esp, input logic [3:0] exv, input logic [7:0] exs);
        checks++;
        if (gnt_valid !== ev || gnt_vc !== evc || gnt_spec !== esp ||
            xbar_valid !== exv || xbar_src !== exs) begin
            fails++;
            $display("FAIL %s: got valid=%b vc=%b spec=%b xv=%b xs=%h exp valid=%b vc=%b spec=%b xv=%b xs=%h",
                     tag, gnt_valid, gnt_vc, gnt_spec, xbar_valid, xbar_src, ev, evc, esp, exv, exs);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [15:0] b, input logic [7:0] c, input logic [15:0] d);
        ns_req = a; ns_dest = b; sp_req = c; sp_dest = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // reset with busy inputs; outputs must stay clear (R1)
    task automatic do_reset();
        rst_n = 1'b0;
        drive(8'hAA, 16'h048C, 8'h55, 16'h0000);
        step();
        step();
        check("R1 in reset", 4'b0, 4'b0, 4'b0, 4'b0, 8'h00);
        drive(8'h00, 16'h0000, 8'h00, 16'h0000);
        rst_n = 1'b1;
        step();
        check("R1 after release", 4'b0, 4'b0, 4'b0, 4'b0, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        @(negedge clk);

        for (int n = 0; n < 9; n++) begin
            do_reset();
            drive(VECS[n].nsr, VECS[n].nsd, VECS[n].spr, VECS[n].spd);
            step();
            check($sformatf("vector %0d R3 R4", n), VECS[n].ev, VECS[n].evc,
                  VECS[n].esp, VECS[n].exv, VECS[n].exs);
        end

        // R2: nothing moves before the edge, result one cycle later, clears one cycle later
        do_reset();
        drive(8'h08, 16'h0080, 8'h00, 16'h0000);
        #1;
        check("R2 before edge", 4'b0, 4'b0, 4'b0, 4'b0, 8'h00);
        step();
        check("R2 after edge", 4'b0010, 4'b0010, 4'b0000, 4'b0100, 8'h10);
        drive(8'h00, 16'h0000, 8'h00, 16'h0000);
        step();
        check("R2 cleared", 4'b0, 4'b0, 4'b0, 4'b0, 8'h00);

        // R9: two VCs of input 1 alternate
        do_reset();
        drive(8'h0C, 16'h0030, 8'h00, 16'h0000);
        step();
        check("R9 first vc0", 4'b0010, 4'b0000, 4'b0000, 4'b1000, 8'h40);
        step();
        check("R9 then vc1", 4'b0010, 4'b0010, 4'b0000, 4'b0001, 8'h01);
        step();
        check("R9 back vc0", 4'b0010, 4'b0000, 4'b0000, 4'b1000, 8'h40);

        // R10: inputs 0 and 1 alternate at output 2
        do_reset();
        drive(8'h05, 16'h0022, 8'h00, 16'h0000);
        step();
        check("R10 first in0", 4'b0001, 4'b0000, 4'b0000, 4'b0100, 8'h00);
        step();
        check("R10 then in1", 4'b0010, 4'b0000, 4'b0000, 4'b0100, 8'h10);
        step();
        check("R10 back in0", 4'b0001, 4'b0000, 4'b0000, 4'b0100, 8'h00);

        // R11: masked spec grant must not move the spec VC pointer
        do_reset();
        drive(8'h04, 16'h0010, 8'h03, 16'h0009);
        step();
        check("R11 spec masked R7", 4'b0010, 4'b0000, 4'b0000, 4'b0010, 8'h04);
        drive(8'h00, 16'h0000, 8'h03, 16'h0009);
        step();
        check("R11 vc0 still first", 4'b0001, 4'b0000, 4'b0001, 4'b0010, 8'h00);
        step();
        check("R11 vc1 after survival", 4'b0001, 4'b0001, 4'b0001, 4'b0100, 8'h00);

        finish_run();
    end

endmodule